// File: doc/BRIEF.md
# Parameterised Set-Associative Cache Controller

A blocking cache placed between a single requester and a slower block memory. The requester reads or writes one byte at a time. Each response says whether the access hit and whether a valid line was displaced to make room. Below the cache, whole blocks move over a request/acknowledge handshake: the cache holds `mem_req` with a stable address until `mem_ack` comes back for one cycle. The number of ways, the number of sets and the block size are parameters. With one way the cache is direct-mapped. A further parameter chooses how writes are handled. In write-through mode every write goes straight to memory. In write-back mode a write marks the line dirty, and the line goes to memory only when it is displaced.

The controller is a five-state machine:
- `ST_IDLE`: the only state with `req_ready` high. It moves to `ST_LOOKUP` when a request is accepted.
- `ST_LOOKUP`: compares every way of the selected set. On a hit it returns to `ST_IDLE`, or goes to `ST_WTHRU` for a write-through write. On a miss it goes to `ST_EVICT` if the victim is dirty in write-back mode, and to `ST_FILL` otherwise.
- `ST_EVICT`: writes the victim block back and moves to `ST_FILL` on acknowledge.
- `ST_FILL`: reads the missing block and installs it. On acknowledge it returns to `ST_LOOKUP`, where the access now completes as a reported miss.
- `ST_WTHRU`: writes the updated block to memory and returns to `ST_IDLE` on acknowledge.

Top module: `cache_ctrl`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the byte offset. The next log2(SETS) bits select the set, and the remaining high bits are the tag.
- R2: An access hits when some valid way of the selected set holds the address tag. On a hit, `resp_valid` is high for exactly one cycle, the cycle after acceptance, with `resp_hit`=1 and `resp_evict`=0.
- R3: A read returns the byte at the offset within the line. That byte is the value most recently written to that address, or the memory content if it was never written.
- R4: On a miss, the block is read with `mem_write`=0 at the request address with its offset bits cleared. The response then carries `resp_hit`=0. While `mem_req` waits for `mem_ack`, the request, direction and address do not change.
- R5: A fill writes the tag and sets the line valid, so a following access to the same block hits.
- R6: The victim is the lowest-numbered invalid way. If every way is valid, the set's pointer chooses the victim. Each hit or fill of way w sets the pointer to (w+1) mod WAYS. `resp_evict`=1 exactly when the victim was valid.
- R7: Write-through (WRITE_BACK=0): every write updates the line and then issues exactly one block write (`mem_write`=1) of the updated block to its base address. Memory always matches the requester's view.
- R8: Write-back (WRITE_BACK=1): a write does not touch memory and marks the line dirty. A dirty victim is written to its own base address before the fill read is issued. A clean victim is not written.
- R9: `req_ready` is high only in `ST_IDLE` and drops for the whole transaction after acceptance. No memory request is made while it is high.
- R10: Reset clears all valid and dirty bits and all pointers. The first access after reset misses with `resp_evict`=0.
- R11: Direct-mapped, with 1 tag bit, 2 index bits and 1 offset bit: reads of 0, 1, 7, 8, 0 give miss, hit, miss, miss with eviction, miss with eviction.
- R12: Two ways, with 2 tag bits, 1 index bit and 1 offset bit: reads of 0, 1, 7, 8, 0 give miss, hit, miss, miss, hit. None of these evicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Cache idle; access accepted when both high |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit without a fill |
| resp_evict | output | 1 | A valid line was displaced |
| resp_rdata | output | 8 | Read byte |
| mem_req | output | 1 | Block transfer request |
| mem_write | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | ADDR_W | Block base address |
| mem_wdata | output | 8*BLOCK_BYTES | Block written to memory |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rdata | input | 8*BLOCK_BYTES | Block read from memory, valid with ack |

## Verification
The bench builds two 4-bit-address instances with 2-byte blocks. The first has two ways, two sets and write-back. Its tiny sets make dirty victims, pointer-driven replacement and the write-back-before-fill ordering happen every few accesses. The second has one way, four sets and write-through. It covers the conflict-eviction trace and shows that memory follows every write. With only sixteen bytes of memory, the random accesses revisit each block constantly. Every corner of replacement and dirtiness is therefore reached many times.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } cache_state_e;
endpackage

// File: rtl/cache_way_match.sv
// Parallel tag compare over all ways of one set; lowest matching way wins.
module cache_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [TAG_W-1:0] way_tags [WAYS],
    input  logic [WAYS-1:0]  way_valid,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_victim_pick.sv
// Victim choice: lowest invalid way, else the set's replacement pointer.
module cache_victim_pick #(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] ptr,
    output logic [WAY_W-1:0] victim
);
    always_comb begin
        victim = ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
// Blocking byte-access cache with parameterised geometry and write policy.
// SETS and BLOCK_BYTES must be powers of two of at least 2.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WAYS        = 2,
    parameter int SETS        = 16,
    parameter int BLOCK_BYTES = 4,
    parameter int WRITE_BACK  = 1,
    localparam int OFF_W = $clog2(BLOCK_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int BLK_W = 8 * BLOCK_BYTES,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_evict,
    output logic [7:0]        resp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata
);
    localparam bit WB = (WRITE_BACK != 0);

    // storage
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [BLK_W-1:0] data_q  [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAY_W-1:0] ptr_q   [SETS];

    // captured request and transaction flags
    cache_state_e      state_q, state_d;
    logic [ADDR_W-1:0] r_addr;
    logic              r_write;
    logic [7:0]        r_wdata;
    logic              r_missed, r_evict;
    logic [WAY_W-1:0]  r_way;

    // R1: field split of the captured address
    logic [OFF_W-1:0] r_off;
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    assign r_off = r_addr[OFF_W-1:0];
    assign r_idx = r_addr[OFF_W +: IDX_W];
    assign r_tag = r_addr[ADDR_W-1 -: TAG_W];

    // view of the selected set
    logic [TAG_W-1:0] set_tags [WAYS];
    logic [BLK_W-1:0] set_data [WAYS];
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w] = tag_q[r_idx][w];
            set_data[w] = data_q[r_idx][w];
        end
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way, victim, ptr_next;

    cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tags  (set_tags),
        .way_valid (valid_q[r_idx]),
        .look_tag  (r_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_victim_pick #(.WAYS(WAYS)) u_victim (
        .way_valid (valid_q[r_idx]),
        .ptr       (ptr_q[r_idx]),
        .victim    (victim)
    );

    assign ptr_next = (hit_way == WAY_W'(WAYS - 1)) ? '0 : hit_way + 1'b1;

    logic accept, victim_dirty;
    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign victim_dirty = WB && valid_q[r_idx][victim] && dirty_q[r_idx][victim];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)               state_d = (r_write && !WB) ? ST_WTHRU : ST_IDLE;
                else if (victim_dirty) state_d = ST_EVICT;
                else                   state_d = ST_FILL;
            end
            ST_EVICT:  if (mem_ack) state_d = ST_FILL;
            ST_FILL:   if (mem_ack) state_d = ST_LOOKUP;
            ST_WTHRU:  if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        mem_req    = 1'b0;
        mem_write  = 1'b0;
        mem_addr   = '0;
        mem_wdata  = set_data[r_way];
        unique case (state_q)
            ST_IDLE:   req_ready  = 1'b1;
            ST_LOOKUP: resp_valid = hit;
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {set_tags[r_way], r_idx, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {r_tag, r_idx, {OFF_W{1'b0}}};
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_write = 1'b1;
                mem_addr  = {r_tag, r_idx, {OFF_W{1'b0}}};
            end
            default: ;
        endcase
    end

    assign resp_hit   = !r_missed;
    assign resp_evict = r_evict;
    assign resp_rdata = set_data[hit_way][{r_off, 3'b000} +: 8];

    // control state: request capture, valid/dirty bits, pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_addr   <= '0;
            r_write  <= 1'b0;
            r_wdata  <= '0;
            r_missed <= 1'b0;
            r_evict  <= 1'b0;
            r_way    <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                ptr_q[s]   <= '0;
            end
        end else begin
            if (accept) begin
                r_addr   <= req_addr;
                r_write  <= req_write;
                r_wdata  <= req_wdata;
                r_missed <= 1'b0;
                r_evict  <= 1'b0;
            end
            if (state_q == ST_LOOKUP) begin
                if (hit) begin
                    r_way        <= hit_way;
                    ptr_q[r_idx] <= ptr_next;
                    if (r_write && WB) dirty_q[r_idx][hit_way] <= 1'b1;
                end else begin
                    r_way    <= victim;
                    r_missed <= 1'b1;
                    r_evict  <= valid_q[r_idx][victim];
                end
            end
            if (state_q == ST_FILL && mem_ack) begin
                valid_q[r_idx][r_way] <= 1'b1;
                dirty_q[r_idx][r_way] <= 1'b0;
            end
        end
    end

    // tag and data arrays are not reset
    always_ff @(posedge clk) begin
        if (state_q == ST_LOOKUP && hit && r_write)
            data_q[r_idx][hit_way][{r_off, 3'b000} +: 8] <= r_wdata;
        if (state_q == ST_FILL && mem_ack) begin
            data_q[r_idx][r_way] <= mem_rdata;
            tag_q[r_idx][r_way]  <= r_tag;
        end
    end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 2,
    parameter int WRITE_BACK = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_evict,
    input logic              mem_req,
    input logic              mem_write,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write)));

    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_hit_no_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> !resp_evict);

    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_evict_then_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK != 0 && mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write));

    p_wb_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK != 0 && resp_valid) |=> !mem_req);
endmodule

bind cache_ctrl cache_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .WRITE_BACK (WRITE_BACK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_evict (resp_evict),
    .mem_req    (mem_req),
    .mem_write  (mem_write),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr)
);

// File: tb/cache_ctrl_test.sv
module cache_ctrl_test;
    // instance 0: 2 ways, 2 sets, write-back; instance 1: 1 way, 4 sets, write-through
    localparam int NW [2] = '{2, 1};
    localparam int NS [2] = '{2, 4};
    localparam int NB [2] = '{1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       rv [2], rw [2], rdy [2], rsv [2], rsh [2], rse [2];
    logic [3:0] ra [2];
    logic [7:0] rd [2], rq [2];
    logic       mreq [2], mwr [2], mack [2];
    logic [3:0] maddr [2];
    logic [15:0] mwd [2], mrd [2];

    int total = 0;
    int bad = 0;

    cache_ctrl #(.ADDR_W(4), .WAYS(2), .SETS(2), .BLOCK_BYTES(2), .WRITE_BACK(1)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rv[0]), .req_ready(rdy[0]), .req_write(rw[0]), .req_addr(ra[0]),
        .req_wdata(rd[0]), .resp_valid(rsv[0]), .resp_hit(rsh[0]), .resp_evict(rse[0]),
        .resp_rdata(rq[0]), .mem_req(mreq[0]), .mem_write(mwr[0]), .mem_addr(maddr[0]),
        .mem_wdata(mwd[0]), .mem_ack(mack[0]), .mem_rdata(mrd[0])
    );

    cache_ctrl #(.ADDR_W(4), .WAYS(1), .SETS(4), .BLOCK_BYTES(2), .WRITE_BACK(0)) uut_dm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rv[1]), .req_ready(rdy[1]), .req_write(rw[1]), .req_addr(ra[1]),
        .req_wdata(rd[1]), .resp_valid(rsv[1]), .resp_hit(rsh[1]), .resp_evict(rse[1]),
        .resp_rdata(rq[1]), .mem_req(mreq[1]), .mem_write(mwr[1]), .mem_addr(maddr[1]),
        .mem_wdata(mwd[1]), .mem_ack(mack[1]), .mem_rdata(mrd[1])
    );

    // lower memory model with operation log
    logic [7:0] lmem [2][16];
    logic       op_w [2][4096];
    logic [3:0] op_a [2][4096];
    int         opn [2];

    function automatic logic [7:0] init_byte(int i, int k);
        return 8'((k * 29 + i * 7 + 5) & 8'hff);
    endfunction

    assign mrd[0] = {lmem[0][{maddr[0][3:1], 1'b1}], lmem[0][{maddr[0][3:1], 1'b0}]};
    assign mrd[1] = {lmem[1][{maddr[1][3:1], 1'b1}], lmem[1][{maddr[1][3:1], 1'b0}]};

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                mack[i] <= 1'b0;
                opn[i]  <= 0;
                for (int k = 0; k < 16; k++) lmem[i][k] <= init_byte(i, k);
            end else begin
                mack[i] <= mreq[i] && !mack[i];
                if (mreq[i] && !mack[i]) begin
                    op_w[i][opn[i] % 4096] <= mwr[i];
                    op_a[i][opn[i] % 4096] <= maddr[i];
                    opn[i] <= opn[i] + 1;
                    if (mwr[i]) begin
                        lmem[i][{maddr[i][3:1], 1'b0}] <= mwd[i][7:0];
                        lmem[i][{maddr[i][3:1], 1'b1}] <= mwd[i][15:8];
                    end
                end
            end
        end
    end

    // bench reference model
    logic [7:0] refm [2][16];
    logic [7:0] lexp [2][16];
    int  mtag [2][4][2];
    bit  mval [2][4][2];
    bit  mdty [2][4][2];
    int  mptr [2][4];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 16; k++) begin
                refm[i][k] = init_byte(i, k);
                lexp[i][k] = init_byte(i, k);
            end
            for (int s = 0; s < 4; s++) begin
                mptr[i][s] = 0;
                for (int w = 0; w < 2; w++) begin
                    mval[i][s][w] = 0;
                    mdty[i][s][w] = 0;
                    mtag[i][s][w] = 0;
                end
            end
        end
    endtask

    // R1 split: offset = bit0, set = next log2(sets) bits, tag = rest
    task automatic access(input int i, input bit wr, input int a, input int d,
                          input string lbl, output bit got_hit, output bit got_evict);
        int  s, t, way, vb, nops, start, b;
        bit  eh, ee, ew [3];
        int  ea [3];
        bit  got;
        logic [7:0] gdata;
        s = (a >> 1) % NS[i];
        t = (a >> 1) / NS[i];
        eh = 0; ee = 0; way = 0; nops = 0;
        for (int w = 0; w < NW[i]; w++)
            if (!eh && mval[i][s][w] && mtag[i][s][w] == t) begin eh = 1; way = w; end
        if (!eh) begin
            way = mptr[i][s];
            for (int w = NW[i] - 1; w >= 0; w--) if (!mval[i][s][w]) way = w;
            ee = mval[i][s][way];
            if (NB[i] == 1 && mval[i][s][way] && mdty[i][s][way]) begin
                vb = (mtag[i][s][way] * NS[i] + s) << 1;
                ew[nops] = 1; ea[nops] = vb; nops++;
                lexp[i][vb] = refm[i][vb];
                lexp[i][vb + 1] = refm[i][vb + 1];
            end
            ew[nops] = 0; ea[nops] = a & 14; nops++;
            mtag[i][s][way] = t; mval[i][s][way] = 1; mdty[i][s][way] = 0;
        end
        mptr[i][s] = (way + 1) % NW[i];
        if (wr) begin
            refm[i][a] = 8'(d);
            if (NB[i] == 1) mdty[i][s][way] = 1;
            else begin
                ew[nops] = 1; ea[nops] = a & 14; nops++;
                lexp[i][a] = 8'(d);
            end
        end

        start = opn[i];
        @(negedge clk);
        rv[i] = 1'b1; rw[i] = wr; ra[i] = 4'(a); rd[i] = 8'(d);
        @(negedge clk);
        rv[i] = 1'b0;
        chk(!rdy[i], "R9", "ready low after accept", int'(rdy[i]), 0);
        got = 0; got_hit = 0; got_evict = 0; gdata = '0;
        for (int c = 0; c < 40; c++) begin
            if (!got && rsv[i]) begin
                got = 1; got_hit = rsh[i]; got_evict = rse[i]; gdata = rq[i];
            end
            if (got && rdy[i]) break;
            @(negedge clk);
        end
        chk(got && rdy[i], "R9", "transaction completes", int'(got), 1);
        chk(got_hit == eh, (lbl != "") ? lbl : "R2", "hit flag", int'(got_hit), int'(eh));
        chk(got_evict == ee, (lbl != "") ? lbl : "R6", "evict flag", int'(got_evict), int'(ee));
        if (!wr) chk(gdata == refm[i][a], "R3", "read byte", int'(gdata), int'(refm[i][a]));
        chk(opn[i] - start == nops, (NB[i] == 1) ? "R8" : "R7", "memory op count",
            opn[i] - start, nops);
        for (int k = 0; k < nops && k < opn[i] - start; k++) begin
            b = (start + k) % 4096;
            chk(op_w[i][b] == ew[k], (ew[k] ? ((NB[i] == 1) ? "R8" : "R7") : "R4"),
                "memory op direction", int'(op_w[i][b]), int'(ew[k]));
            chk(int'(op_a[i][b]) == ea[k], "R4", "memory op base address",
                int'(op_a[i][b]), ea[k]);
        end
        for (int k = 0; k < 16; k++)
            if (lmem[i][k] != lexp[i][k])
                chk(0, (NB[i] == 1) ? "R8" : "R7", "lower memory byte",
                    int'(lmem[i][k]), int'(lexp[i][k]));
        total++;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        bit h, e;
        int seed, a, d;
        bit wr;
        bit dm_hit [5], dm_ev [5], tw_hit [5];
        int trace [5];
        trace = '{0, 1, 7, 8, 0};
        dm_hit = '{0, 1, 0, 0, 0};
        dm_ev  = '{0, 0, 0, 1, 1};
        tw_hit = '{0, 1, 0, 0, 1};
        for (int i = 0; i < 2; i++) begin
            rv[i] = 0; rw[i] = 0; ra[i] = '0; rd[i] = '0;
        end
        model_reset();
        seed = $urandom(32'd24681);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int i = 0; i < 2; i++) begin
            chk(rdy[i] == 1'b1, "R10", "ready after reset", int'(rdy[i]), 1);
            chk(rsv[i] == 1'b0, "R10", "no response after reset", int'(rsv[i]), 0);
            chk(mreq[i] == 1'b0, "R10", "no memory request after reset", int'(mreq[i]), 0);
        end

        // R11: direct-mapped trace
        for (int k = 0; k < 5; k++) begin
            access(1, 0, trace[k], 0, "R11", h, e);
            chk(h == dm_hit[k], "R11", "trace hit", int'(h), int'(dm_hit[k]));
            chk(e == dm_ev[k], "R11", "trace evict", int'(e), int'(dm_ev[k]));
            if (k == 0) chk(!h && !e, "R10", "first access cold miss", int'(e), 0);
        end
        // R12: two-way trace
        for (int k = 0; k < 5; k++) begin
            access(0, 0, trace[k], 0, "R12", h, e);
            chk(h == tw_hit[k], "R12", "trace hit", int'(h), int'(tw_hit[k]));
            chk(!e, "R12", "trace evict", int'(e), 0);
        end

        // R8: dirty write stays in cache, then clean victim, then dirty victim written back
        access(0, 1, 0, 8'hA5, "", h, e);
        chk(lmem[0][0] == init_byte(0, 0), "R8", "write hit leaves memory", int'(lmem[0][0]),
            int'(init_byte(0, 0)));
        access(0, 0, 4, 0, "", h, e);   // clean victim way1 (R6 pointer)
        access(0, 0, 12, 0, "", h, e);  // dirty victim way0: write-back then fill
        chk(lmem[0][0] == 8'hA5, "R8", "dirty line written at eviction", int'(lmem[0][0]), 8'hA5);
        access(0, 0, 0, 0, "", h, e);   // R5 refill returns written byte
        access(0, 0, 1, 0, "R5", h, e); // same block hits after fill
        // R7: write-through on hit and on miss
        access(1, 1, 1, 8'h3C, "", h, e);
        access(1, 1, 10, 8'hC3, "", h, e);
        access(1, 0, 10, 0, "R5", h, e);

        // random mix
        for (int n = 0; n < 600; n++) begin
            a  = int'($urandom_range(0, 15));
            d  = int'($urandom_range(0, 255));
            wr = ($urandom_range(0, 2) == 0);
            access(n % 2, wr, a, d, "", h, e);
        end

        report();
        $finish;
    end
endmodule